// File: doc/BRIEF.md
# Virtual-Path Bit Lookup Table

This block holds a 4096-entry table of single bits that sits beside a content-addressable match array. Whenever a comparand is presented with the compare strobe, the block uses the comparand's twelve most significant bits as an index and reports, one clock later, whether that bit is set. In a cascade of such arrays, only the device at the bottom of the priority chain should report this result. For that reason the result is gated by a configuration enable, which is cleared by reset.

Software controls the table through a small opcode port. It can read a bit, set a bit or reset a bit, one index at a time, and a separate opcode wipes the whole table in one cycle. These operations act on the stored bits whether or not the lookup is enabled. The stored bits are not touched by the block reset, so a table built before a reset is still present afterwards.

Top module: `vpt_lookup`

## Requirements
- R1: A compare uses comparand bits 31 down to 20 as the table index. Bits 19 down to 0 have no effect on the result.
- R2: `match_vld_o` is high exactly in the cycle after a cycle with `cmp_valid_i` high. `match_o` is low in every other cycle.
- R3: The lookup enable is 0 after reset. It changes only on a clock edge where `cfg_we_i` is high, and it then takes the value of `cfg_en_i`.
- R4: While the enable is 0, a compare still raises `match_vld_o`, but `match_o` is 0 whatever bit is stored at that index.
- R5: The opcode values are read = 2'b00, set = 2'b01, reset = 2'b10 and clear = 2'b11, and an opcode is issued by holding `op_valid_i` high for one cycle. Set writes 1 and reset writes 0 at `op_index_i`. For a read, `rd_data_o` shows the stored bit one cycle later, together with `rd_vld_o`. All of these work whether the lookup is enabled or not.
- R6: The clear opcode makes every entry 0 in a single cycle.
- R7: Asserting `rst_ni` does not change the stored bits.
- R8: When a set or reset happens in the same cycle as a compare to the same index, the compare reports the value the bit held before the write.
- R9: A set or reset changes only the addressed entry. Neighbouring indices and the extreme indices 0 and 4095 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the control and result registers |
| cfg_we_i | input | 1 | Loads the lookup enable from `cfg_en_i` |
| cfg_en_i | input | 1 | New value of the lookup enable |
| cmp_valid_i | input | 1 | Compare strobe |
| cmp_data_i | input | 32 | Comparand; the top 12 bits form the index |
| op_valid_i | input | 1 | Opcode strobe |
| op_code_i | input | 2 | Opcode: read, set, reset or clear |
| op_index_i | input | 12 | Entry index used by the opcode |
| match_o | output | 1 | Table-match result, gated by the enable |
| match_vld_o | output | 1 | Pulses one cycle after each compare |
| rd_data_o | output | 1 | Bit returned by a read |
| rd_vld_o | output | 1 | Pulses one cycle after a read |

## Verification
A corrupted storage word or a wrong index slice shows up as a wrong `match_o` or `rd_data_o` on the first compare or read that hits the affected entry, one clock after the request. That is why the bench sweeps every index after writing a sparse pattern, and then probes the extremes and the neighbours of each written bit. A stuck or misloaded enable shows on the very next compare as a `match_o` that disagrees with the stored bit while `match_vld_o` is still high. A write that wins against a concurrent compare shows up in the same one-cycle window as a premature match.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_SET   = 2'b01,
    OP_RESET = 2'b10,
    OP_CLEAR = 2'b11
  } vpt_op_e;
endpackage

// File: rtl/vpt_bitstore.sv
module vpt_bitstore #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cmp_idx_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic             wr_en_i,
  input  logic             wr_val_i,
  input  logic             clr_i,
  output logic             cmp_bit_o,
  output logic             op_bit_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int SEL_W = $clog2(WORD_W);
  localparam int WORDS = DEPTH / WORD_W;
  localparam int ADR_W = IDX_W - SEL_W;

  function automatic logic [ADR_W-1:0] word_of(input logic [IDX_W-1:0] idx);
    return idx[IDX_W-1:SEL_W];
  endfunction

  function automatic logic [SEL_W-1:0] bit_of(input logic [IDX_W-1:0] idx);
    return idx[SEL_W-1:0];
  endfunction

  logic [WORD_W-1:0] mem [WORDS];
  logic [ADR_W-1:0]  wr_word_w;
  logic [SEL_W-1:0]  wr_bit_w;
  logic              any_set_w;

  assign wr_word_w = word_of(op_idx_i);
  assign wr_bit_w  = bit_of(op_idx_i);

  // Reads see the contents before this edge's write (old-value semantics).
  assign cmp_bit_o = mem[word_of(cmp_idx_i)][bit_of(cmp_idx_i)];
  assign op_bit_o  = mem[wr_word_w][wr_bit_w];

  // No reset on the array: contents survive a block reset.
  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (wr_en_i) begin
      mem[wr_word_w][wr_bit_w] <= wr_val_i;
    end
  end

  always_comb begin
    any_set_w = 1'b0;
    for (int w = 0; w < WORDS; w++) any_set_w = any_set_w | (|mem[w]);
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> (mem[$past(wr_word_w)][$past(wr_bit_w)] == $past(wr_val_i))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_set_w); // R6
endmodule

// File: rtl/vpt_cfg.sv
module vpt_cfg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  assign en_o = en_q;

  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> $past(cfg_we_i)); // R3
endmodule

// File: rtl/vpt_result.sv
module vpt_result (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_valid_i,
  input  logic cmp_bit_i,
  input  logic en_i,
  input  logic rd_req_i,
  input  logic rd_bit_i,
  output logic match_o,
  output logic match_vld_o,
  output logic rd_data_o,
  output logic rd_vld_o
);
  logic match_q, match_vld_q, rd_q, rd_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q     <= 1'b0;
      match_vld_q <= 1'b0;
      rd_q        <= 1'b0;
      rd_vld_q    <= 1'b0;
    end else begin
      match_q     <= cmp_valid_i & en_i & cmp_bit_i;
      match_vld_q <= cmp_valid_i;
      rd_vld_q    <= rd_req_i;
      if (rd_req_i) rd_q <= rd_bit_i;
    end
  end

  assign match_o     = match_q;
  assign match_vld_o = match_vld_q;
  assign rd_data_o   = rd_q;
  assign rd_vld_o    = rd_vld_q;

  AST_VLD_AFTER_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> match_vld_o); // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> !match_vld_o); // R2
  AST_MATCH_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(en_i) && match_vld_o)); // R4
  AST_READ_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_vld_o); // R5
endmodule

// File: rtl/vpt_lookup.sv
module vpt_lookup
  import vpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              cmp_valid_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [IDX_W-1:0]  op_index_i,
  output logic              match_o,
  output logic              match_vld_o,
  output logic              rd_data_o,
  output logic              rd_vld_o
);
  localparam int LOW_W = DATA_W - IDX_W;

  vpt_op_e          op_w;
  logic [IDX_W-1:0] cmp_idx_w;
  logic             unused_low_w;
  logic             wr_en_w, wr_val_w, clr_w, rd_req_w;
  logic             en_w, cmp_bit_w, op_bit_w;

  assign op_w         = vpt_op_e'(op_code_i);
  assign cmp_idx_w    = cmp_data_i[DATA_W-1 -: IDX_W];
  assign unused_low_w = ^cmp_data_i[LOW_W-1:0];

  always_comb begin
    wr_en_w  = 1'b0;
    wr_val_w = 1'b0;
    clr_w    = 1'b0;
    rd_req_w = 1'b0;
    if (op_valid_i) begin
      unique case (op_w)
        OP_READ:  rd_req_w = 1'b1;
        OP_SET:   begin wr_en_w = 1'b1; wr_val_w = 1'b1; end
        OP_RESET: wr_en_w = 1'b1;
        OP_CLEAR: clr_w = 1'b1;
        default:  ;
      endcase
    end
  end

  vpt_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .cfg_en_i (cfg_en_i),
    .en_o     (en_w)
  );

  vpt_bitstore #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_idx_i (cmp_idx_w),
    .op_idx_i  (op_index_i),
    .wr_en_i   (wr_en_w),
    .wr_val_i  (wr_val_w),
    .clr_i     (clr_w),
    .cmp_bit_o (cmp_bit_w),
    .op_bit_o  (op_bit_w)
  );

  vpt_result u_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmp_valid_i (cmp_valid_i),
    .cmp_bit_i   (cmp_bit_w),
    .en_i        (en_w),
    .rd_req_i    (rd_req_w),
    .rd_bit_i    (op_bit_w),
    .match_o     (match_o),
    .match_vld_o (match_vld_o),
    .rd_data_o   (rd_data_o),
    .rd_vld_o    (rd_vld_o)
  );

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !en_w) |=> !match_o); // R4
  AST_ONE_OP_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_w, clr_w, rd_req_w})); // R5
endmodule

// File: tb/vpt_lookup_bench.sv
`timescale 1ns/1ps
module vpt_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_data = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [11:0] op_index = '0;
  logic        match, match_vld, rd_data, rd_vld;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  vpt_lookup u_vpt_lookup (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .cmp_valid_i(cmp_valid), .cmp_data_i(cmp_data),
    .op_valid_i(op_valid), .op_code_i(op_code), .op_index_i(op_index),
    .match_o(match), .match_vld_o(match_vld), .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_en = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] c, input int idx);
    @(negedge clk); op_valid = 1'b1; op_code = c; op_index = idx[11:0];
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic read_bit(input int idx, output logic v, output logic vld);
    @(negedge clk); op_valid = 1'b1; op_code = 2'b00; op_index = idx[11:0];
    @(negedge clk); v = rd_data; vld = rd_vld; op_valid = 1'b0;
  endtask

  task automatic compare(input int idx, input logic [19:0] low, output logic m, output logic mv);
    @(negedge clk); cmp_valid = 1'b1; cmp_data = {idx[11:0], low};
    @(negedge clk); m = match; mv = match_vld; cmp_valid = 1'b0;
  endtask

  task automatic cmp_with_write(input int idx, input logic [1:0] c, output logic m);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_data = {idx[11:0], 20'h0};
    op_valid = 1'b1; op_code = c; op_index = idx[11:0];
    @(negedge clk); m = match; cmp_valid = 1'b0; op_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Reset state and enable default
  task automatic t_reset_state();
    logic m, mv;
    check("R2 reset match", match, 1'b0);
    check("R2 reset match_vld", match_vld, 1'b0);
    check("R5 reset rd_vld", rd_vld, 1'b0);
    do_op(2'b11, 0);
    do_op(2'b01, 5);
    compare(5, 20'h0, m, mv);
    check("R3 enable off after reset", m, 1'b0);
    check("R2 vld after compare", mv, 1'b1);
    @(negedge clk);
    check("R2 vld drops when idle", match_vld, 1'b0);
  endtask

  // Disabled table: ops still work, match gated
  task automatic t_disabled_ops();
    logic v, vld, m, mv;
    read_bit(5, v, vld);
    check("R5 read while disabled", v, 1'b1);
    check("R5 rd_vld", vld, 1'b1);
    do_op(2'b01, 9);
    compare(9, 20'hABCDE, m, mv);
    check("R4 disabled match low", m, 1'b0);
    check("R4 disabled vld high", mv, 1'b1);
    do_op(2'b10, 9);
    read_bit(9, v, vld);
    check("R5 reset op while disabled", v, 1'b0);
  endtask

  // Enabled lookup, index slice, neighbours
  task automatic t_lookup();
    logic m, mv;
    set_en(1'b1);
    compare(5, 20'h0, m, mv);
    check("R1 match set index", m, 1'b1);
    compare(5, 20'hFFFFF, m, mv);
    check("R1 low bits ignored", m, 1'b1);
    compare(4, 20'h0, m, mv);
    check("R9 neighbour below", m, 1'b0);
    compare(6, 20'hFFFFF, m, mv);
    check("R9 neighbour above", m, 1'b0);
    compare(5 + 256, 20'h0, m, mv);
    check("R1 other high bits", m, 1'b0);
    do_op(2'b01, 0);
    do_op(2'b01, 4095);
    compare(0, 20'h12345, m, mv);
    check("R9 index 0", m, 1'b1);
    compare(4095, 20'h0, m, mv);
    check("R9 index 4095", m, 1'b1);
    compare(4094, 20'h0, m, mv);
    check("R9 index 4094", m, 1'b0);
    compare(1, 20'h0, m, mv);
    check("R9 index 1", m, 1'b0);
    set_en(1'b0);
    compare(4095, 20'h0, m, mv);
    check("R3 enable cleared by write", m, 1'b0);
    set_en(1'b1);
  endtask

  // Same-cycle write and compare
  task automatic t_collision();
    logic m, mv;
    cmp_with_write(77, 2'b01, m);
    check("R8 set during compare sees old 0", m, 1'b0);
    compare(77, 20'h0, m, mv);
    check("R8 set visible next compare", m, 1'b1);
    cmp_with_write(77, 2'b10, m);
    check("R8 reset during compare sees old 1", m, 1'b1);
    compare(77, 20'h0, m, mv);
    check("R8 reset visible next compare", m, 1'b0);
  endtask

  // Reset preserves contents
  task automatic t_reset_keeps();
    logic m, mv, v, vld;
    pulse_reset();
    compare(4095, 20'h0, m, mv);
    check("R3 enable off after second reset", m, 1'b0);
    read_bit(4095, v, vld);
    check("R7 contents survive reset", v, 1'b1);
    set_en(1'b1);
    compare(5, 20'h0, m, mv);
    check("R7 lookup after reset", m, 1'b1);
  endtask

  // Clear and full sweep of a sparse pattern
  task automatic t_clear_sweep();
    logic m, mv, v, vld;
    int bad;
    do_op(2'b11, 0);
    compare(4095, 20'h0, m, mv);
    check("R6 clear top entry", m, 1'b0);
    compare(5, 20'h0, m, mv);
    check("R6 clear entry 5", m, 1'b0);
    for (int i = 0; i < 4096; i += 37) do_op(2'b01, i);
    bad = 0;
    for (int i = 0; i < 4096; i++) begin
      read_bit(i, v, vld);
      if (v !== ((i % 37) == 0)) begin
        bad++;
        if (bad < 4) $display("FAIL R9 sweep idx %0d: actual %b expected %b", i, v, (i % 37) == 0);
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    compare(37 * 3, 20'h55555, m, mv);
    check("R1 sweep compare", m, 1'b1);
    do_op(2'b11, 0);
    read_bit(37, v, vld);
    check("R6 clear after pattern", v, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_disabled_ops();
    t_lookup();
    t_collision();
    t_reset_keeps();
    t_clear_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule